// File: doc/BRIEF.md
# CRC-Checked Page Write Buffer

This block sits behind a serial front-end that has already turned the serial line into whole bytes. A protected write arrives as a stream of bytes: two address bytes that carry a 15-bit array address, then up to one page of data bytes, then a two-byte check value. The block holds the data back in a page-sized buffer. It runs a 16-bit CRC over the address and the data while the bytes arrive.

When the front-end signals that chip enable has returned high, the block compares the received check value against its own result. The buffered bytes go to the array write port only when the two agree and the transaction ended on a byte boundary. Any disagreement discards the whole transaction and raises a sticky error flag that software reads as bit 4 of its status byte. A corrupted address or a corrupted data byte therefore never changes the array.

Top module: `secure_page_writer`

## Requirements
- R1: After reset, `mem_we`, `sec_err` and `busy` are all low.
- R2: The check value is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, shifted MSB first. It covers the first address byte with its bit 7 forced to 0, then the second address byte, then every data byte. The last two bytes of the transaction are the check value, high byte first, and are never stored as data. On a match, every data byte is written to the array once, in arrival order, with one `mem_we` pulse per byte.
- R3: If any data byte is corrupted, so that the check fails, no `mem_we` pulse occurs and `sec_err` reads 1 once `busy` falls.
- R4: If an address byte is corrupted while the data is correct, no `mem_we` pulse occurs and `sec_err` reads 1.
- R5: `sec_err` is cleared to 0 in the cycle after a transaction starts. Otherwise it keeps its value until the next start.
- R6: A transaction that ends with `txn_partial` high is dropped: no `mem_we` pulse occurs and `sec_err` stays 0.
- R7: Data byte i (counting from 0) is written to the address made of base bits [14:6] and (base bits [5:0] + i) mod 64. Writes therefore wrap within the 64-byte page.
- R8: A transaction with more than 64 data bytes, or with fewer than four bytes in total, writes nothing and sets `sec_err`. Exactly 64 data bytes is accepted.
- R9: A byte strobe that arrives in the same cycle as `txn_end` still belongs to the transaction.
- R10: Byte strobes and end pulses that arrive with no transaction open cause no write, leave `busy` low and leave `sec_err` unchanged.
- R11: Bit 7 of the first address byte has no effect on the write addresses or on the check.
- R12: A transaction that passes the check with zero data bytes writes nothing and leaves `sec_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | One-cycle pulse: a protected write begins |
| byte_valid | input | 1 | A received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| txn_end | input | 1 | One-cycle pulse: chip enable has returned high |
| txn_partial | input | 1 | Qualifies `txn_end`: the last byte was incomplete |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |
| sec_err | output | 1 | Sticky check-failure flag (status bit 4) |
| busy | output | 1 | A transaction is open, being checked or being committed |

## Verification
The last byte strobe and the end-of-transaction pulse can occur in the same cycle. The block must then fold the second check byte into the held tail before it runs the comparison. The bench provokes this in a directed mode, and often in random traffic, by raising `txn_end` together with the final `byte_valid`. It judges the result by whether the full page reaches the write port with `sec_err` low. If the byte were dropped, the check would fail and nothing would be written.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RECV,
    S_CHECK,
    S_COMMIT
  } swb_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // one byte through the CRC register, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                              input logic [7:0]  b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/swb_crc16.sv
module swb_crc16
  import swb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= CRC_SEED;
    else if (upd)   crc_q <= crc16_step(crc_q, din);
  end

  // a fresh transaction starts from the seed value
  assert_crc_seed_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/swb_holdback.sv
module swb_holdback #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic [2*W-1:0] tail
);

  logic [W-1:0] older_q, newer_q;
  logic [1:0]   fill_q;

  assign full     = (fill_q == 2'd2);
  assign pop      = push && full;
  assign pop_data = older_q;
  assign tail     = {older_q, newer_q};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill_q  <= 2'd0;
      older_q <= '0;
      newer_q <= '0;
    end else if (push) begin
      older_q <= newer_q;
      newer_q <= din;
      if (!full) fill_q <= fill_q + 2'd1;
    end
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fill_q != 2'd3);

endmodule

// File: rtl/swb_page_buf.sv
module swb_page_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/secure_page_writer.sv
module secure_page_writer
  import swb_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE   = 64,
  localparam int PG_W  = $clog2(PAGE),
  localparam int NW    = PG_W + 1,
  localparam int CNT_W = $clog2(PAGE + 3) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              txn_end,
  input  logic              txn_partial,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sec_err,
  output logic              busy
);

  localparam int HI_W = ADDR_W - 8;

  swb_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  pop_idx_q;
  logic              ovf_q;
  logic              partial_q;
  logic [NW-1:0]     n_data_q;
  logic [NW-1:0]     cnt_q;
  logic              err_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;

  logic              start_acc;
  logic              push;
  logic              pop;
  logic [7:0]        pop_data;
  logic              hb_full;
  logic [15:0]       hb_tail;
  logic [15:0]       crc_q;
  logic [7:0]        crc_din;
  logic [CNT_W-1:0]  data_idx;
  logic              is_data;
  logic              buf_we;
  logic              chk_ok;

  assign start_acc = txn_start && (state_q == S_IDLE);
  assign push      = byte_valid && (state_q == S_RECV);
  assign data_idx  = pop_idx_q - CNT_W'(2);
  assign is_data   = (pop_idx_q >= CNT_W'(2));
  assign buf_we    = pop && is_data && !ovf_q && (data_idx < CNT_W'(PAGE));
  assign crc_din   = (pop_idx_q == '0) ? {1'b0, pop_data[6:0]} : pop_data;
  assign chk_ok    = hb_full && is_data && !ovf_q && (hb_tail == crc_q);

  swb_holdback #(.W(8)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_acc),
    .push     (push),
    .din      (byte_data),
    .pop      (pop),
    .pop_data (pop_data),
    .full     (hb_full),
    .tail     (hb_tail)
  );

  swb_crc16 u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_acc),
    .upd   (pop),
    .din   (crc_din),
    .crc_q (crc_q)
  );

  swb_page_buf #(.DEPTH(PAGE), .DW(8)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_addr (data_idx[PG_W-1:0]),
    .wr_data (pop_data),
    .rd_en   (state_q == S_COMMIT),
    .rd_addr (cnt_q[PG_W-1:0]),
    .rd_q    (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      base_q    <= '0;
      pop_idx_q <= '0;
      ovf_q     <= 1'b0;
      partial_q <= 1'b0;
      n_data_q  <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (txn_start) begin
            err_q     <= 1'b0;
            pop_idx_q <= '0;
            ovf_q     <= 1'b0;
            state_q   <= S_RECV;
          end
        end
        S_RECV: begin
          if (pop) begin
            if (pop_idx_q == CNT_W'(0)) base_q[ADDR_W-1:8] <= pop_data[HI_W-1:0];
            if (pop_idx_q == CNT_W'(1)) base_q[7:0] <= pop_data;
            if (is_data && (data_idx >= CNT_W'(PAGE))) ovf_q <= 1'b1;
            else if (!ovf_q) pop_idx_q <= pop_idx_q + CNT_W'(1);
          end
          if (txn_end) begin
            partial_q <= txn_partial;
            state_q   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (partial_q) begin
            state_q <= S_IDLE;
          end else if (chk_ok) begin
            n_data_q <= NW'(data_idx);
            cnt_q    <= '0;
            state_q  <= (data_idx == '0) ? S_IDLE : S_COMMIT;
          end else begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_COMMIT: begin
          cnt_q <= cnt_q + NW'(1);
          if (cnt_q == n_data_q - NW'(1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // registered write port, aligned with the buffer's registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      we_q   <= (state_q == S_COMMIT);
      addr_q <= {base_q[ADDR_W-1:PG_W], base_q[PG_W-1:0] + cnt_q[PG_W-1:0]};
    end
  end

  assign mem_we   = we_q;
  assign mem_addr = addr_q;
  assign sec_err  = err_q;
  assign busy     = (state_q != S_IDLE) || we_q;

  assert_no_write_on_err_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !sec_err);

  assert_err_clear_R5: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> !sec_err);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (sec_err && !txn_start) |=> sec_err);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_COMMIT) |-> (n_data_q <= NW'(PAGE)) && (n_data_q != '0));

  assert_page_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |->
      (mem_addr[ADDR_W-1:PG_W] == $past(mem_addr[ADDR_W-1:PG_W])) &&
      (mem_addr[PG_W-1:0] == $past(mem_addr[PG_W-1:0]) + PG_W'(1)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_IDLE) && !txn_start) |=> (state_q == S_IDLE));

endmodule

// File: tb/secure_page_writer_bench.sv
module secure_page_writer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        txn_end = 1'b0;
  logic        txn_partial = 1'b0;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        sec_err;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [14:0] exp_addr [70];
  logic [7:0]  exp_data [70];
  int exp_n = 0;
  int wr_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  secure_page_writer u_secure_page_writer (
    .clk(clk), .rst(rst), .txn_start(txn_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .txn_end(txn_end), .txn_partial(txn_partial),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sec_err(sec_err), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bit-serial CRC-16, feedback polynomial 0x1021, MSB first
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[15] ^ b[7-k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // write port monitor (R2, R7)
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (wr_seen < exp_n) begin
        chk(mem_addr == exp_addr[wr_seen], "R7", "write address", mem_addr, exp_addr[wr_seen]);
        chk(mem_wdata == exp_data[wr_seen], "R2", "write data", mem_wdata, exp_data[wr_seen]);
      end else begin
        chk(0, "R3", "unexpected write", wr_seen, exp_n);
      end
      wr_seen++;
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      finish_up();
    end
  end

  // mode: 0 good, 1 data corrupt, 2 address corrupt, 3 partial, 4 end with last byte
  task automatic run_txn(input logic [14:0] a, input logic b7, input int n,
                         input int mode, input string req);
    logic [7:0] bs [72];
    logic [15:0] c;
    bit exp_err;
    int total = n + 4;
    bs[0] = {b7, a[14:8]};
    bs[1] = a[7:0];
    for (int i = 0; i < n; i++) bs[i+2] = 8'($urandom);
    c = 16'hFFFF;
    c = ref_crc(c, {1'b0, a[14:8]});
    c = ref_crc(c, a[7:0]);
    for (int i = 0; i < n; i++) c = ref_crc(c, bs[i+2]);
    bs[n+2] = c[15:8];
    bs[n+3] = c[7:0];
    if (mode == 1) bs[2] = bs[2] ^ 8'h08;
    if (mode == 2) bs[1] = bs[1] ^ 8'h01;
    exp_n = 0;
    if ((mode == 0 || mode == 4) && n <= 64) begin
      exp_n = n;
      for (int i = 0; i < n; i++) begin
        exp_addr[i] = {a[14:6], 6'(a[5:0] + 6'(i))};
        exp_data[i] = bs[i+2];
      end
    end
    exp_err = (mode == 1) || (mode == 2) || ((mode != 3) && n > 64);
    wr_seen = 0;
    @(negedge clk); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0;
    chk(sec_err == 1'b0, "R5", "flag cleared at start", sec_err, 0);
    for (int i = 0; i < total; i++) begin
      byte_valid = 1'b1;
      byte_data  = bs[i];
      if (mode == 4 && i == total - 1) txn_end = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      txn_end = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
    if (mode != 4) begin
      txn_end = 1'b1;
      txn_partial = (mode == 3);
      @(negedge clk);
      txn_end = 1'b0;
      txn_partial = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(wr_seen == exp_n, req, "write count", wr_seen, exp_n);
    chk(sec_err == exp_err, req, "error flag", sec_err, exp_err);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
    chk(sec_err == 1'b0, "R1", "sec_err after reset", sec_err, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // R10: stray strobes with no open transaction
    exp_n = 0; wr_seen = 0;
    for (int i = 0; i < 6; i++) begin
      byte_valid = 1'b1; byte_data = 8'(i * 37);
      @(negedge clk);
    end
    byte_valid = 1'b0; txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_seen == 0, "R10", "stray writes", wr_seen, 0);
    chk(busy == 1'b0, "R10", "busy on stray", busy, 0);
    chk(sec_err == 1'b0, "R10", "flag on stray", sec_err, 0);

    run_txn(15'h1234, 1'b1, 10, 0, "R2");      // R2, R11
    run_txn(15'h2A7C, 1'b0, 12, 0, "R7");      // wraps at the page edge
    run_txn(15'h0100, 1'b0, 8, 1, "R3");
    repeat (6) @(negedge clk);
    chk(sec_err == 1'b1, "R5", "flag sticky while idle", sec_err, 1);
    run_txn(15'h0300, 1'b0, 8, 2, "R4");
    run_txn(15'h0500, 1'b0, 5, 3, "R6");
    run_txn(15'h7FC0, 1'b1, 64, 0, "R8");      // full page accepted
    run_txn(15'h0040, 1'b0, 65, 0, "R8");      // one too many
    run_txn(15'h1111, 1'b0, 64, 4, "R9");
    run_txn(15'h4321, 1'b1, 0, 0, "R12");
    run_txn(15'h3FFF, 1'b1, 1, 0, "R11");

    for (int t = 0; t < 40; t++) begin
      int m = $urandom % 5;
      int n = 1 + ($urandom % 64);
      run_txn(15'($urandom), 1'($urandom), n, m, "R2");
    end

    done = 1;
    finish_up();
  end

endmodule